// File: doc/BRIEF.md
# Pin Function Multiplexer and Output Latch Bank

This block is a memory-mapped GPIO core for 54 pins. Software gives every pin a 3-bit function code that makes it a plain input, a plain output driven from a per-pin output latch, or a pin handed to one of six alternate peripherals. The output latches are never written directly. One register sets latch bits and a second register clears them, each acting only where a 1 is written. Software can therefore change one pin without reading and rewriting its neighbours.

The incoming pad level passes through a two-flop synchronizer and can be read back in a level register. The slave bus is a plain 32-bit register port with address, write strobe, write data and read data. Reads are combinational from the address. Writes take effect at the rising clock edge on which the strobe is high. The six alternate peripherals are modelled by input ports that supply a value and an enable for each pin.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset every function field reads 0 (input), every output latch is 0 and pad_oe is 0 on all pins.
- R2: Function words start at byte address 0x00. Pin p sits in the word at byte address (p/10)*4, in bits [(p%10)*3+2:(p%10)*3]. A write stores the fields and a read returns them. Bits 31:30 of each word and the field positions past pin 53 (bits 31:12 of the word at 0x14) read 0.
- R3: When a pin's code is 1 (output), pad_oe is 1 and pad_out equals the pin's output latch.
- R4: When a pin's code is 0 (input), pad_oe is 0. The latch still accepts set and clear writes, and the value shows on pad_out once the pin becomes an output.
- R5: A write to 0x1C (pins 0–31, bit p) or 0x20 (pins 32–53, bit p-32) sets the latch of each pin whose bit is 1. Bits written as 0 leave their latch unchanged.
- R6: A write to 0x28 (pins 0–31) or 0x2C (pins 32–53) clears the latch of each pin whose bit is 1. Bits written as 0 leave their latch unchanged.
- R7: Reads of 0x1C, 0x20, 0x28 and 0x2C return 0.
- R8: A read of 0x34 returns pad_in[31:0], and a read of 0x38 returns pad_in[53:32] in bits 21:0 with the upper bits 0. The value is the one sampled through two flops: a change on pad_in appears in a read after the second rising edge that follows it.
- R9: Codes 4, 5, 6, 7, 3 and 2 select alternates 0, 1, 2, 3, 4 and 5. Under alternate a, pad_out[p] = alt_val[a*54+p] and pad_oe[p] = alt_en[a*54+p].
- R10: A pin's output latch keeps its value while the pin is under an alternate function. Set and clear writes made during that time still update it, and the latch drives the pad again when the code returns to 1.
- R11: Writes to unmapped addresses (for example 0x18 or 0x24) change no function field and no latch, and those addresses read 0. Output latches change only through the set and clear registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 54 | Level arriving from each pad |
| pad_out | output | 54 | Value driven toward each pad |
| pad_oe | output | 54 | Output enable for each pad |
| alt_val | input | 324 | Per-alternate, per-pin output value, index a*54+p |
| alt_en | input | 324 | Per-alternate, per-pin output enable, index a*54+p |

## Verification
The hardest case to reach is the out-of-order code map. Each code must route exactly one of six alternate buses, and a wrong but plausible permutation would still move a value to the pad. For one pin, the stimulus steps through every alternate code, and under each code it drives a single alternate bus high at a time. Each of the 36 code and bus pairs then shows which bus reaches the pad. The latch-retention case is reached by writing the set register while the pin is under an alternate function, then switching the pin back to output.

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank #(
  parameter int NUM_PINS      = 54,
  parameter int FSEL_W        = 3,
  parameter int PINS_PER_WORD = 10,
  parameter int NUM_ALT       = 6,
  parameter int AW            = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 bus_addr,
  input  logic                          bus_we,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_PINS-1:0]           pad_in,
  output logic [NUM_PINS-1:0]           pad_out,
  output logic [NUM_PINS-1:0]           pad_oe,
  input  logic [NUM_ALT*NUM_PINS-1:0]   alt_val,
  input  logic [NUM_ALT*NUM_PINS-1:0]   alt_en
);
  localparam int BIT_WORDS = (NUM_PINS + 31) / 32;
  localparam int PAD_BITS  = BIT_WORDS * 32;
  localparam logic [AW-1:0] A_SET = AW'(8'h1C);
  localparam logic [AW-1:0] A_CLR = AW'(8'h28);
  localparam logic [AW-1:0] A_LEV = AW'(8'h34);

  logic [FSEL_W-1:0]   fsel_q [NUM_PINS];
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] sync1, sync2;
  logic [PAD_BITS-1:0] lev_pad;

  function automatic int alt_sel(input logic [FSEL_W-1:0] code);
    case (code)
      3'd4:    return 0;
      3'd5:    return 1;
      3'd6:    return 2;
      3'd7:    return 3;
      3'd3:    return 4;
      default: return 5;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) fsel_q[p] <= '0;
      out_q <= '0;
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bus_we && bus_addr == AW'((p / PINS_PER_WORD) * 4))
          fsel_q[p] <= bus_wdata[(p % PINS_PER_WORD)*FSEL_W +: FSEL_W];
        if (bus_we && bus_addr == A_SET + AW'((p / 32) * 4) && bus_wdata[p % 32])
          out_q[p] <= 1'b1;
        else if (bus_we && bus_addr == A_CLR + AW'((p / 32) * 4) && bus_wdata[p % 32])
          out_q[p] <= 1'b0;
      end
    end
  end

  assign lev_pad = PAD_BITS'(sync2);

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (bus_addr == AW'((p / PINS_PER_WORD) * 4))
        bus_rdata[(p % PINS_PER_WORD)*FSEL_W +: FSEL_W] = fsel_q[p];
    for (int w = 0; w < BIT_WORDS; w++)
      if (bus_addr == A_LEV + AW'(w * 4))
        bus_rdata = lev_pad[w*32 +: 32];
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pad_out[p] = out_q[p];
      pad_oe[p]  = 1'b0;
      if (fsel_q[p] == FSEL_W'(1)) begin
        pad_oe[p] = 1'b1;
      end else if (fsel_q[p] != '0) begin
        pad_out[p] = alt_val[alt_sel(fsel_q[p])*NUM_PINS + p];
        pad_oe[p]  = alt_en[alt_sel(fsel_q[p])*NUM_PINS + p];
      end
    end
  end
endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [31:0]   pad_in_lo,
  input logic          pad_oe0,
  input logic          pad_out0,
  input logic [31:0]   out_lo
);
  localparam logic [AW-1:0] A_SET0 = AW'(8'h1C);
  localparam logic [AW-1:0] A_SET1 = AW'(8'h20);
  localparam logic [AW-1:0] A_CLR0 = AW'(8'h28);
  localparam logic [AW-1:0] A_CLR1 = AW'(8'h2C);
  localparam logic [AW-1:0] A_LEV0 = AW'(8'h34);

  logic [1:0] cyc;
  always_ff @(posedge clk)
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;

  p_set_word0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET0) |=> out_lo == ($past(out_lo) | $past(bus_wdata)));

  p_clr_word0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR0) |=> out_lo == ($past(out_lo) & ~$past(bus_wdata)));

  p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != A_SET0 && bus_addr != A_CLR0) |=> $stable(out_lo));

  p_setclr_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SET0 || bus_addr == A_SET1 || bus_addr == A_CLR0 || bus_addr == A_CLR1)
      |-> bus_rdata == 32'h0);

  p_level_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && bus_addr == A_LEV0) |-> bus_rdata == $past(pad_in_lo, 2));

  p_output_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0 && bus_rdata[2:0] == 3'd1) |-> (pad_oe0 && pad_out0 == out_lo[0]));

  p_input_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0 && bus_rdata[2:0] == 3'd0) |-> !pad_oe0);

  p_word_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> bus_rdata[31:30] == 2'b00);
endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in_lo (pad_in[31:0]),
  .pad_oe0   (pad_oe[0]),
  .pad_out0  (pad_out[0]),
  .out_lo    (out_q[31:0])
);

// File: tb/sim_gpio_mux_bank.sv
module sim_gpio_mux_bank;
  localparam int N = 54;
  localparam int NA = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic [NA*N-1:0] alt_val = '0;
  logic [NA*N-1:0] alt_en = '0;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  gpio_mux_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_val(alt_val), .alt_en(alt_en)
  );

  // address, write data, expected read-back at the same address
  localparam logic [71:0] VEC [10] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
    {8'h14, 32'hFFFF_FFFF, 32'h0000_0FFF},
    {8'h08, 32'h2468_ACE1, 32'h2468_ACE1},
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h28, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h2C, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h24, 32'hAAAA_AAAA, 32'h0000_0000},
    {8'h0C, 32'h0000_0000, 32'h0000_0000}
  };
  localparam string VTAG [10] = '{"R2", "R2", "R2", "R7", "R7", "R7", "R7", "R11", "R11", "R2"};
  // code -> alternate index (R9); -1 for non-alternate codes
  localparam int ALT_OF [8] = '{-1, -1, 5, 4, 0, 1, 2, 3};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int w = 0; w < 6; w++) begin
      rd(8'(w*4), v);
      chk(v, 32'h0, "R1 function word");
    end
    chk({10'h0, pad_oe}, 64'h0, "R1 pad_oe");
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk(v, VEC[i][31:0], VTAG[i]);
    end
    // R11 unmapped writes left the function words alone
    rd(8'h14, v); chk(v, 32'h0000_0FFF, "R11 word 0x14 kept");
    rd(8'h00, v); chk(v, 32'h3FFF_FFFF, "R11 word 0x00 kept");

    for (int w = 0; w < 6; w++) wr(8'(w*4), 32'h0);

    // R3 / R5 / R6 on pin 0
    wr(8'h00, 32'h1);
    wr(8'h1C, 32'h1);
    chk({pad_oe[0], pad_out[0]}, 2'b11, "R3 output drives latch 1");
    wr(8'h1C, 32'h0);
    chk(pad_out[0], 1'b1, "R5 zero bits no effect");
    wr(8'h28, 32'h0);
    chk(pad_out[0], 1'b1, "R6 zero bits no effect");
    wr(8'h28, 32'h1);
    chk({pad_oe[0], pad_out[0]}, 2'b10, "R6 clear pin 0");

    // R5 / R6 upper word, pin 53 (word 0x14 bits 11:9)
    wr(8'h14, 32'h1 << 9);
    wr(8'h20, 32'h1 << 21);
    chk({pad_oe[53], pad_out[53]}, 2'b11, "R5 set pin 53");
    wr(8'h2C, 32'h1 << 21);
    chk(pad_out[53], 1'b0, "R6 clear pin 53");

    // R4 input pin keeps latch
    wr(8'h1C, 32'h2);
    chk(pad_oe[1], 1'b0, "R4 input pin released");
    wr(8'h00, 32'h9);
    chk({pad_oe[1], pad_out[1]}, 2'b11, "R4 latch shown after output");

    // R9 alternate code map on pin 2 (bits 8:6)
    for (int c = 2; c < 8; c++) begin
      wr(8'h00, 32'(c) << 6);
      for (int a = 0; a < NA; a++) begin
        alt_val = '0; alt_en = '0;
        alt_val[a*N+2] = 1'b1;
        alt_en[a*N+2]  = 1'b1;
        #1;
        chk({pad_oe[2], pad_out[2]}, (ALT_OF[c] == a) ? 2'b11 : 2'b00, "R9 alternate routing");
      end
    end
    alt_val = '0; alt_en = '0;

    // R10 latch updates while under alternate
    wr(8'h00, 32'h4 << 6);
    wr(8'h1C, 32'h4);
    chk(pad_out[2], 1'b0, "R10 alternate owns pad");
    wr(8'h00, 32'h1 << 6);
    chk({pad_oe[2], pad_out[2]}, 2'b11, "R10 latch set during alternate");
    wr(8'h00, 32'h5 << 6);
    wr(8'h28, 32'h4);
    wr(8'h00, 32'h1 << 6);
    chk(pad_out[2], 1'b0, "R10 latch cleared during alternate");

    // R8 two-flop level sampling
    @(negedge clk);
    pad_in = {22'h3F_FFFF, 32'hC0DE_5A5A};
    @(negedge clk);
    rd(8'h34, v); chk(v, 32'h0, "R8 not yet after one edge");
    @(negedge clk);
    rd(8'h34, v); chk(v, 32'hC0DE_5A5A, "R8 low word");
    rd(8'h38, v); chk(v, 32'h003F_FFFF, "R8 high word");

    finish_run();
  end
endmodule